// File: doc/BRIEF.md
# PTP event timestamp capture latch

This block records the free-running 64-bit system time at the start of a precision-time-protocol event frame. There are two independent capture slots, one for the receive path and one for the transmit path. Each slot holds a captured time together with a valid flag. Once a slot has captured, it is locked: it ignores every later event until software strobes a read of the stamp's high word, which frees it again. An unread receive stamp therefore blocks all further receive timestamping.

On the receive side, the frame parser hands the block a descriptor in the start-of-frame cycle. The descriptor carries the ethertype, a UDP flag, the UDP destination port, the PTP version and the message type. A two-bit filter mode decides which messages qualify:

- The version-1 mode matches one configured message type on the configured event port.
- The version-2 mode takes every version-2 event message. It accepts either UDP frames on the event port or layer-2 frames with ethertype 0x88F7. Layer-2 frames count only when the layer-2 enable is set.

On the transmit side, software marks at most one frame for stamping, and the slot captures the first marked start-of-frame.

The descriptor and the start-of-frame strobes are valid-only inputs with no back-pressure. The block takes each strobe in the cycle it is high and never stalls the datapath. A strobe that does not qualify, or that arrives while its slot is locked, is dropped without trace.

Top module: `ptp_stamp_latch`

## Requirements
- R1: After reset both valid flags are 0 and both stamps are 0.
- R2: In filter mode 0 (version 1 over UDP) with receive enabled, a receive start-of-frame qualifies when the UDP flag is 1, the destination port equals the configured event port, the version is 1 and the message type equals the configured version-1 type (0 Sync, 1 Delay_Req). A qualifying frame sets the receive valid flag after that clock edge, and the stamp equals the system time sampled at that edge.
- R3: In mode 0, a frame with a wrong port, a wrong message type, version 2, or the UDP flag at 0 is not captured.
- R4: In filter mode 1 (version 2 events), version-2 messages with a type of 0 to 3 qualify. These are Sync, Delay_Req, Pdelay_Req and Pdelay_Resp. Types 4 and above (for example 8 or 11) are never captured.
- R5: In mode 1, a non-UDP frame qualifies through ethertype 0x88F7 only when the layer-2 enable is 1. A UDP frame qualifies when its destination port equals the event port.
- R6: While a valid flag is 1, further events in that direction change neither the stamp nor the flag.
- R7: A high-word read strobe clears that direction's valid flag after the edge. An event in the same cycle as the read is dropped. The next event after that is captured.
- R8: The transmit slot captures on a start-of-frame with the mark bit at 1 and transmit enabled. Unmarked frames are ignored.
- R9: With a direction's enable at 0, its valid flag is 0 after the next edge and no event in that direction is captured.
- R10: The two directions are independent: a read or an event on one side never changes the other side's flag or stamp.
- R11: Filter modes 2 and 3 are reserved and capture nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time_i | input | 64 | Free-running system time |
| rx_en_i | input | 1 | Receive capture enable |
| rx_mode_i | input | 2 | Filter mode: 0 v1 UDP, 1 v2 events, 2/3 reserved |
| cfg_event_port_i | input | 16 | UDP event port to match |
| cfg_v1_msg_i | input | 4 | Version-1 message type to match |
| cfg_l2_en_i | input | 1 | Allow layer-2 capture via ethertype 0x88F7 |
| rx_sof_i | input | 1 | Receive start-of-frame strobe, descriptor valid |
| rx_ethertype_i | input | 16 | Frame ethertype |
| rx_is_udp_i | input | 1 | Frame carries UDP |
| rx_udp_dport_i | input | 16 | UDP destination port |
| rx_ptp_ver_i | input | 4 | PTP version |
| rx_msg_type_i | input | 4 | PTP message type |
| rx_rd_hi_i | input | 1 | Receive high-word read strobe |
| rx_valid_o | output | 1 | Receive stamp held |
| rx_stamp_o | output | 64 | Receive captured time |
| tx_en_i | input | 1 | Transmit capture enable |
| tx_sof_i | input | 1 | Transmit start-of-frame strobe |
| tx_mark_i | input | 1 | Transmit frame marked for stamping |
| tx_rd_hi_i | input | 1 | Transmit high-word read strobe |
| tx_valid_o | output | 1 | Transmit stamp held |
| tx_stamp_o | output | 64 | Transmit captured time |

## Verification
The valid flags and stamps drive the outputs straight from their registers. A wrong lock state therefore shows one cycle after the event or read that exposes it. A slot stuck locked shows as a missing capture on the next qualifying frame. A slot that fails to lock shows as a stamp that moves on a later event. A filter decode error shows as a capture, or a missed capture, one edge after the offending descriptor. The stamp value pins down which edge's time was sampled, so an off-by-one in the sampling edge shows as a time off by one increment.

// File: rtl/ptp_latch_pkg.sv
package ptp_latch_pkg;
  localparam int PORT_W = 16;
  localparam int ETYPE_W = 16;
  localparam int VER_W = 4;
  localparam int MSG_W = 4;
  localparam logic [ETYPE_W-1:0] ETYPE_PTP = 16'h88F7;

  typedef enum logic [1:0] {
    FLT_V1_UDP   = 2'd0,
    FLT_V2_EVENT = 2'd1,
    FLT_RSV_2    = 2'd2,
    FLT_RSV_3    = 2'd3
  } flt_mode_e;

  typedef struct packed {
    logic [ETYPE_W-1:0] ethertype;
    logic               is_udp;
    logic [PORT_W-1:0]  dport;
    logic [VER_W-1:0]   ver;
    logic [MSG_W-1:0]   msg;
  } rx_desc_t;
endpackage

// File: rtl/ptp_rx_filter.sv
module ptp_rx_filter
  import ptp_latch_pkg::*;
(
  input  flt_mode_e         mode_i,
  input  logic [PORT_W-1:0] port_cfg_i,
  input  logic [MSG_W-1:0]  v1_msg_cfg_i,
  input  logic              l2_en_i,
  input  rx_desc_t          desc_i,
  output logic              match_o
);
  logic port_hit, v1_ok, v2_type_ok, v2_path_ok;

  always_comb begin
    port_hit   = desc_i.is_udp && (desc_i.dport == port_cfg_i);
    v1_ok      = port_hit && (desc_i.ver == VER_W'(1)) && (desc_i.msg == v1_msg_cfg_i);
    v2_type_ok = (desc_i.ver == VER_W'(2)) && (desc_i.msg[MSG_W-1:2] == '0);
    v2_path_ok = port_hit || (l2_en_i && !desc_i.is_udp && (desc_i.ethertype == ETYPE_PTP));
    unique case (mode_i)
      FLT_V1_UDP:   match_o = v1_ok;
      FLT_V2_EVENT: match_o = v2_type_ok && v2_path_ok;
      default:      match_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptp_cap_slot.sv
module ptp_cap_slot #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          hit_i,
  input  logic          rd_hi_i,
  input  logic [TW-1:0] time_i,
  output logic          valid_o,
  output logic [TW-1:0] stamp_o
);
  logic          valid_q;
  logic [TW-1:0] stamp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      stamp_q <= '0;
    end else if (!en_i || rd_hi_i) begin
      valid_q <= 1'b0;
    end else if (!valid_q && hit_i) begin
      valid_q <= 1'b1;
      stamp_q <= time_i;
    end
  end

  assign valid_o = valid_q;
  assign stamp_o = stamp_q;

  // R2 / R8: a free slot captures the time of the qualifying edge
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && hit_i && en_i && !rd_hi_i) |=> (valid_q && stamp_q == $past(time_i)));
  // R6: a locked slot holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && en_i && !rd_hi_i) |=> (valid_q && $stable(stamp_q)));
  // R7: a high-word read frees the slot
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi_i |=> !valid_q);
  // R9: disabled slot is empty
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !valid_q);
endmodule

// File: rtl/ptp_stamp_latch.sv
module ptp_stamp_latch
  import ptp_latch_pkg::*;
#(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] sys_time_i,
  input  logic          rx_en_i,
  input  logic [1:0]    rx_mode_i,
  input  logic [15:0]   cfg_event_port_i,
  input  logic [3:0]    cfg_v1_msg_i,
  input  logic          cfg_l2_en_i,
  input  logic          rx_sof_i,
  input  logic [15:0]   rx_ethertype_i,
  input  logic          rx_is_udp_i,
  input  logic [15:0]   rx_udp_dport_i,
  input  logic [3:0]    rx_ptp_ver_i,
  input  logic [3:0]    rx_msg_type_i,
  input  logic          rx_rd_hi_i,
  output logic          rx_valid_o,
  output logic [TW-1:0] rx_stamp_o,
  input  logic          tx_en_i,
  input  logic          tx_sof_i,
  input  logic          tx_mark_i,
  input  logic          tx_rd_hi_i,
  output logic          tx_valid_o,
  output logic [TW-1:0] tx_stamp_o
);
  localparam int NDIR = 2;
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;

  rx_desc_t desc;
  logic     rx_match;
  logic     rx_hit;

  assign desc.ethertype = rx_ethertype_i;
  assign desc.is_udp    = rx_is_udp_i;
  assign desc.dport     = rx_udp_dport_i;
  assign desc.ver       = rx_ptp_ver_i;
  assign desc.msg       = rx_msg_type_i;

  ptp_rx_filter u_filter (
    .mode_i       (flt_mode_e'(rx_mode_i)),
    .port_cfg_i   (cfg_event_port_i),
    .v1_msg_cfg_i (cfg_v1_msg_i),
    .l2_en_i      (cfg_l2_en_i),
    .desc_i       (desc),
    .match_o      (rx_match)
  );

  assign rx_hit = rx_sof_i && rx_match;

  logic [NDIR-1:0]         en_v, hit_v, rd_v, val_v;
  logic [NDIR-1:0][TW-1:0] stamp_v;

  assign en_v[DIR_RX]  = rx_en_i;
  assign hit_v[DIR_RX] = rx_hit;
  assign rd_v[DIR_RX]  = rx_rd_hi_i;
  assign en_v[DIR_TX]  = tx_en_i;
  assign hit_v[DIR_TX] = tx_sof_i && tx_mark_i;
  assign rd_v[DIR_TX]  = tx_rd_hi_i;

  for (genvar d = 0; d < NDIR; d++) begin : g_slot
    ptp_cap_slot #(.TW(TW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en_v[d]),
      .hit_i   (hit_v[d]),
      .rd_hi_i (rd_v[d]),
      .time_i  (sys_time_i),
      .valid_o (val_v[d]),
      .stamp_o (stamp_v[d])
    );
  end

  assign rx_valid_o = val_v[DIR_RX];
  assign rx_stamp_o = stamp_v[DIR_RX];
  assign tx_valid_o = val_v[DIR_TX];
  assign tx_stamp_o = stamp_v[DIR_TX];

  // R11: reserved modes never qualify
  a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode_i[1] |-> !rx_hit);
  // R4: only event types qualify in version-2 mode
  a_r4_event_types: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode_i == 2'd1 && rx_hit) |-> (rx_msg_type_i < 4'd4));
  // R10: a receive read leaves the transmit slot alone
  a_r10_independent: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_hi_i && tx_valid_o && tx_en_i && !tx_rd_hi_i) |=> (tx_valid_o && $stable(tx_stamp_o)));
endmodule

// File: tb/sim_ptp_stamp_latch.sv
module sim_ptp_stamp_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_time = 64'h1000;
  logic        rx_en = 1'b0, cfg_l2_en = 1'b0, rx_sof = 1'b0, rx_is_udp = 1'b0, rx_rd_hi = 1'b0;
  logic [1:0]  rx_mode = 2'd0;
  logic [15:0] cfg_port = 16'd319, rx_ethertype = 16'h0800, rx_dport = 16'd0;
  logic [3:0]  cfg_v1_msg = 4'd0, rx_ver = 4'd0, rx_msg = 4'd0;
  logic        tx_en = 1'b0, tx_sof = 1'b0, tx_mark = 1'b0, tx_rd_hi = 1'b0;
  logic        rx_valid, tx_valid;
  logic [63:0] rx_stamp, tx_stamp;

  int checks = 0, errors = 0;
  logic        m_rxv = 1'b0, m_txv = 1'b0;
  logic [63:0] m_rxs = '0, m_txs = '0;
  logic [63:0] exp_t;

  always #4 clk = ~clk;

  ptp_stamp_latch u0 (
    .clk(clk), .rst_n(rst_n), .sys_time_i(sys_time),
    .rx_en_i(rx_en), .rx_mode_i(rx_mode), .cfg_event_port_i(cfg_port),
    .cfg_v1_msg_i(cfg_v1_msg), .cfg_l2_en_i(cfg_l2_en), .rx_sof_i(rx_sof),
    .rx_ethertype_i(rx_ethertype), .rx_is_udp_i(rx_is_udp), .rx_udp_dport_i(rx_dport),
    .rx_ptp_ver_i(rx_ver), .rx_msg_type_i(rx_msg), .rx_rd_hi_i(rx_rd_hi),
    .rx_valid_o(rx_valid), .rx_stamp_o(rx_stamp),
    .tx_en_i(tx_en), .tx_sof_i(tx_sof), .tx_mark_i(tx_mark), .tx_rd_hi_i(tx_rd_hi),
    .tx_valid_o(tx_valid), .tx_stamp_o(tx_stamp)
  );

  always @(posedge clk) sys_time <= sys_time + 64'd8;

  function automatic bit qualifies();
    bit port_ok = rx_is_udp && rx_dport == cfg_port;
    if (rx_mode == 2'd0)
      return port_ok && rx_ver == 4'd1 && rx_msg == cfg_v1_msg;
    if (rx_mode == 2'd1) begin
      if (rx_ver != 4'd2 || rx_msg > 4'd3) return 0;
      return port_ok || (cfg_l2_en && !rx_is_udp && rx_ethertype == 16'h88F7);
    end
    return 0;
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_rxv = 0; m_txv = 0; m_rxs = '0; m_txs = '0;
    end else begin
      if (!rx_en || rx_rd_hi) m_rxv = 0;
      else if (!m_rxv && rx_sof && qualifies()) begin m_rxv = 1; m_rxs = sys_time; end
      if (!tx_en || tx_rd_hi) m_txv = 0;
      else if (!m_txv && tx_sof && tx_mark) begin m_txv = 1; m_txs = sys_time; end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R6 lock behaviour among others)
  always begin
    @(posedge clk);
    #2;
    if (rst_n) begin
      chk("R6 model rx_valid", {63'd0, rx_valid}, {63'd0, m_rxv});
      chk("R6 model rx_stamp", rx_stamp, m_rxs);
      chk("R8 model tx_valid", {63'd0, tx_valid}, {63'd0, m_txv});
      chk("R8 model tx_stamp", tx_stamp, m_txs);
    end
  end

  task automatic rx_evt(input bit udp, input logic [15:0] et, input logic [15:0] port,
                        input logic [3:0] ver, input logic [3:0] msg);
    @(negedge clk);
    rx_is_udp = udp; rx_ethertype = et; rx_dport = port; rx_ver = ver; rx_msg = msg;
    rx_sof = 1'b1; exp_t = sys_time;
    @(negedge clk);
    rx_sof = 1'b0;
  endtask

  task automatic rx_read();
    @(negedge clk); rx_rd_hi = 1'b1;
    @(negedge clk); rx_rd_hi = 1'b0;
  endtask

  task automatic tx_evt(input bit mark);
    @(negedge clk); tx_sof = 1'b1; tx_mark = mark; exp_t = sys_time;
    @(negedge clk); tx_sof = 1'b0; tx_mark = 1'b0;
  endtask

  logic [63:0] held;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rx_valid", {63'd0, rx_valid}, 64'd0);
    chk("R1 tx_valid", {63'd0, tx_valid}, 64'd0);
    chk("R1 rx_stamp", rx_stamp, 64'd0);
    chk("R1 tx_stamp", tx_stamp, 64'd0);

    rx_en = 1'b1; rx_mode = 2'd0; cfg_v1_msg = 4'd1;
    rx_evt(1, 16'h0800, 16'd319, 4'd1, 4'd1);
    chk("R2 capture valid", {63'd0, rx_valid}, 64'd1);
    chk("R2 capture time", rx_stamp, exp_t);
    held = rx_stamp;
    rx_evt(1, 16'h0800, 16'd319, 4'd1, 4'd1);
    chk("R6 locked stamp", rx_stamp, held);
    chk("R6 locked valid", {63'd0, rx_valid}, 64'd1);
    rx_read();
    chk("R7 read clears", {63'd0, rx_valid}, 64'd0);

    rx_evt(1, 16'h0800, 16'd320, 4'd1, 4'd1);
    rx_evt(1, 16'h0800, 16'd319, 4'd1, 4'd0);
    rx_evt(1, 16'h0800, 16'd319, 4'd2, 4'd1);
    rx_evt(0, 16'h0800, 16'd319, 4'd1, 4'd1);
    chk("R3 mismatches ignored", {63'd0, rx_valid}, 64'd0);
    rx_evt(1, 16'h0800, 16'd319, 4'd1, 4'd1);
    chk("R7 next event captured", rx_stamp, exp_t);

    // read and event in the same cycle
    @(negedge clk);
    rx_rd_hi = 1'b1; rx_sof = 1'b1;
    @(negedge clk);
    rx_rd_hi = 1'b0; rx_sof = 1'b0;
    chk("R7 same-cycle event dropped", {63'd0, rx_valid}, 64'd0);

    rx_mode = 2'd1;
    rx_evt(1, 16'h0800, 16'd319, 4'd2, 4'd8);
    rx_evt(1, 16'h0800, 16'd319, 4'd2, 4'd11);
    chk("R4 non-event ignored", {63'd0, rx_valid}, 64'd0);
    rx_evt(1, 16'h0800, 16'd319, 4'd2, 4'd2);
    chk("R4 pdelay captured", rx_stamp, exp_t);
    rx_read();
    rx_evt(1, 16'h0800, 16'd319, 4'd2, 4'd3);
    chk("R4 pdelay resp captured", rx_stamp, exp_t);
    rx_read();

    rx_evt(0, 16'h88F7, 16'd0, 4'd2, 4'd0);
    chk("R5 l2 disabled ignored", {63'd0, rx_valid}, 64'd0);
    cfg_l2_en = 1'b1;
    rx_evt(0, 16'h88F7, 16'd0, 4'd2, 4'd0);
    chk("R5 l2 captured", rx_stamp, exp_t);
    chk("R5 l2 valid", {63'd0, rx_valid}, 64'd1);
    rx_read();

    rx_mode = 2'd2;
    rx_evt(1, 16'h0800, 16'd319, 4'd2, 4'd0);
    rx_mode = 2'd3;
    rx_evt(0, 16'h88F7, 16'd0, 4'd1, 4'd1);
    chk("R11 reserved modes", {63'd0, rx_valid}, 64'd0);

    tx_en = 1'b1;
    tx_evt(0);
    chk("R8 unmarked ignored", {63'd0, tx_valid}, 64'd0);
    tx_evt(1);
    chk("R8 marked captured", tx_stamp, exp_t);
    held = tx_stamp;
    tx_evt(1);
    chk("R6 tx locked", tx_stamp, held);

    rx_mode = 2'd1;
    rx_evt(1, 16'h0800, 16'd319, 4'd2, 4'd0);
    rx_read();
    chk("R10 tx untouched by rx read", tx_stamp, held);
    chk("R10 tx valid kept", {63'd0, tx_valid}, 64'd1);
    @(negedge clk); tx_rd_hi = 1'b1;
    @(negedge clk); tx_rd_hi = 1'b0;
    chk("R10 tx read frees tx", {63'd0, tx_valid}, 64'd0);
    rx_evt(1, 16'h0800, 16'd319, 4'd2, 4'd0);
    chk("R10 rx unaffected by tx", {63'd0, rx_valid}, 64'd1);

    tx_evt(1);
    tx_en = 1'b0; rx_en = 1'b0;
    @(negedge clk);
    chk("R9 tx disable clears", {63'd0, tx_valid}, 64'd0);
    chk("R9 rx disable clears", {63'd0, rx_valid}, 64'd0);
    tx_evt(1);
    rx_evt(1, 16'h0800, 16'd319, 4'd2, 4'd0);
    chk("R9 tx disabled ignores", {63'd0, tx_valid}, 64'd0);
    chk("R9 rx disabled ignores", {63'd0, rx_valid}, 64'd0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule